// File: doc/BRIEF.md
# Cache Block Flush and Purge Controller

This block carries out a processor request to flush or purge one cache block in a second-level cache. A flush writes back dirty private data before the line is dropped. A purge drops the line without writing anything back. The block accepts one command at a time through a valid/ready handshake. In the cycle after acceptance it compares the block number against every valid outstanding-miss register. If a miss is already in flight for that block, the command is folded into it: the command kind is written into the register's pending-operation field, and the command completes as a memory-level hit.

When no miss register matches, the block uses the tag lookup result for that cycle. On a tag miss it does nothing to the line and completes as a memory-level hit. On a tag hit it invalidates the line and clears its tag in that cycle, and completes as a second-level hit. It then issues the follow-up traffic in order. First it sends invalidation messages to the first-level coherence queues. The instruction-side message is always sent. The data-side message is sent only for a flush when the first-level data cache runs in write-back mode. After that, for a flush of a dirty line only, it sends a write-back request into the data-array request pipe. When a required queue or the pipe is full, the block waits and retries. The tag action is never repeated during these retries.

Top module: `flush_purge_ctrl`

## Requirements
- R1: After reset `cmd_ready` is 1, and `done`, `tag_inval`, `mreg_pend_we`, `useless_pref` and all push outputs are 0.
- R2: In the cycle after a command is accepted (the lookup cycle), if any miss register has `mreg_valid` set and its block equal to the command block, the block pulses `mreg_pend_we` with the lowest such index on `mreg_pend_idx`, drives `mreg_pend_flush` to 1 for a flush and 0 for a purge, does not pulse `tag_inval`, and completes with `done_l2hit`=0. Registers whose valid bit is clear are never matched.
- R3: With no register match and `tag_hit`=1 in the lookup cycle, `tag_inval` pulses in that cycle only, and the command completes with `done_l2hit`=1.
- R4: With no register match and `tag_hit`=0, there is no `tag_inval` and no push, and the command completes with `done_l2hit`=0 in the cycle after lookup.
- R5: Every tag hit produces exactly one `iq_push`.
- R6: A tag hit produces one `dq_push` only when the command is a flush and `l1d_wb_mode`=1, and no `dq_push` otherwise.
- R7: A tag hit produces one `wb_push` only for a flush with `tag_dirty`=1. A purge never writes back, even when the line is dirty.
- R8: The required invalidations are pushed together in one cycle, and only when none of the required queues is full. A full flag on a queue that is not required causes no stall. `tag_inval` is not repeated during a stall.
- R9: The write-back is pushed only after the invalidation cycle, in the first later cycle with `wb_full`=0.
- R10: `cmd_ready` is 1 only while idle. A command is accepted on a clock edge with `cmd_valid` and `cmd_ready` both high.
- R11: `done` pulses for one cycle in the cycle after the last required push (or after the lookup cycle when there is no push), and `cmd_ready` returns in the following cycle.
- R12: `useless_pref` pulses in the lookup cycle when a tag hit invalidates a line whose `tag_pref` bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_flush | input | 1 | 1 = flush, 0 = purge |
| cmd_block | input | BLK_W | Target block number |
| mreg_valid | input | NUM_MREG | Valid bits of outstanding-miss registers |
| mreg_block | input | NUM_MREG*BLK_W | Block numbers of miss registers, entry k at bits k*BLK_W |
| mreg_pend_we | output | 1 | Write pending-operation field |
| mreg_pend_idx | output | IDX_W | Miss register to write |
| mreg_pend_flush | output | 1 | Pending operation kind, 1 = flush |
| tag_block | output | BLK_W | Block being looked up |
| tag_hit | input | 1 | Lookup hit |
| tag_dirty | input | 1 | Hit line is private-dirty |
| tag_pref | input | 1 | Hit line was brought in by prefetch |
| tag_inval | output | 1 | Invalidate line and clear its tag |
| l1d_wb_mode | input | 1 | First-level data cache is write-back |
| iq_push | output | 1 | Push invalidation to instruction-side queue |
| iq_full | input | 1 | Instruction-side queue full |
| dq_push | output | 1 | Push invalidation to data-side queue |
| dq_full | input | 1 | Data-side queue full |
| wb_push | output | 1 | Push write-back into data-array request pipe |
| wb_full | input | 1 | Data-array request pipe full |
| push_block | output | BLK_W | Block carried by all pushes |
| done | output | 1 | Command complete pulse |
| done_l2hit | output | 1 | With done: 1 = second-level hit, 0 = memory-level hit |
| useless_pref | output | 1 | Invalidated line was an unused prefetch |

## Verification
The bench holds several miss registers valid and matching at once, to check that the lowest index wins. It also places a register with the matching block but its valid bit clear: a design that ignored the valid bit would merge the command instead of looking at the tags. Dirty purges check that no write-back goes out, and queue-full stalls check that the invalidation pair leaves in one cycle and that the tag invalidate is not repeated. A full flag is raised on a queue the command does not need, and a design that stalled on it would end late. Stalls on the write-back pipe alone and on the queues alone each shift `done` by exactly the stall length, so a design with an off-by-one handoff fails the cycle-by-cycle comparison.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_ISSUE  = 2'd2,
        ST_DONE   = 2'd3
    } fpc_state_e;

    typedef struct packed {
        fpc_state_e st;
        logic       flush;
        logic       need_i;
        logic       need_d;
        logic       need_wb;
        logic       l2hit;
    } fpc_ctl_t;

endpackage

// File: rtl/fpc_mreg_match.sv
module fpc_mreg_match #(
    parameter int NUM_MREG = 8,
    parameter int BLK_W    = 20,
    localparam int IDX_W   = (NUM_MREG > 1) ? $clog2(NUM_MREG) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_MREG-1:0]       valid,
    input  logic [NUM_MREG*BLK_W-1:0] blocks,
    input  logic [BLK_W-1:0]          key,
    output logic                      hit,
    output logic [IDX_W-1:0]          idx
);

    logic [NUM_MREG-1:0] eq;

    for (genvar g = 0; g < NUM_MREG; g++) begin : g_cmp
        assign eq[g] = valid[g] && (blocks[g*BLK_W +: BLK_W] == key);
    end

    // lowest matching index wins
    always_comb begin
        idx = '0;
        for (int i = NUM_MREG - 1; i >= 0; i--) begin
            if (eq[i]) idx = IDX_W'(i);
        end
    end

    assign hit = |eq;

    // R2: a reported match always points at a valid register
    a_r2_idx_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> valid[idx]);

endmodule

// File: rtl/fpc_push_sel.sv
module fpc_push_sel (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    input  logic need_i,
    input  logic need_d,
    input  logic need_wb,
    input  logic iq_full,
    input  logic dq_full,
    input  logic wb_full,
    output logic iq_push,
    output logic dq_push,
    output logic wb_push,
    output logic q_go,
    output logic last
);

    logic q_pend;
    logic q_room;

    always_comb begin
        q_pend  = need_i || need_d;
        q_room  = !(need_i && iq_full) && !(need_d && dq_full);
        q_go    = active && q_pend && q_room;
        iq_push = q_go && need_i;
        dq_push = q_go && need_d;
        wb_push = active && !q_pend && need_wb && !wb_full;
        last    = (q_go && !need_wb) || wb_push;
    end

    // R9: the write-back never shares a cycle with the invalidation pair
    a_r9_wb_after_queues: assert property (@(posedge clk) disable iff (!rst_n)
        wb_push |-> !iq_push && !dq_push);

    // R8: after the pair is pushed, no further invalidation follows
    a_r8_pair_once: assert property (@(posedge clk) disable iff (!rst_n)
        (iq_push || dq_push) |=> !(iq_push || dq_push));

endmodule

// File: rtl/flush_purge_ctrl.sv
module flush_purge_ctrl #(
    parameter int NUM_MREG = 8,
    parameter int BLK_W    = 20,
    localparam int IDX_W   = (NUM_MREG > 1) ? $clog2(NUM_MREG) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_valid,
    output logic                      cmd_ready,
    input  logic                      cmd_flush,
    input  logic [BLK_W-1:0]          cmd_block,
    input  logic [NUM_MREG-1:0]       mreg_valid,
    input  logic [NUM_MREG*BLK_W-1:0] mreg_block,
    output logic                      mreg_pend_we,
    output logic [IDX_W-1:0]          mreg_pend_idx,
    output logic                      mreg_pend_flush,
    output logic [BLK_W-1:0]          tag_block,
    input  logic                      tag_hit,
    input  logic                      tag_dirty,
    input  logic                      tag_pref,
    output logic                      tag_inval,
    input  logic                      l1d_wb_mode,
    output logic                      iq_push,
    input  logic                      iq_full,
    output logic                      dq_push,
    input  logic                      dq_full,
    output logic                      wb_push,
    input  logic                      wb_full,
    output logic [BLK_W-1:0]          push_block,
    output logic                      done,
    output logic                      done_l2hit,
    output logic                      useless_pref
);

    import fpc_pkg::*;

    fpc_ctl_t         ctl_d, ctl_q;
    logic [BLK_W-1:0] blk_d, blk_q;

    logic             m_hit;
    logic [IDX_W-1:0] m_idx;
    logic             issuing;
    logic             q_go;
    logic             last;

    fpc_mreg_match #(
        .NUM_MREG (NUM_MREG),
        .BLK_W    (BLK_W)
    ) u_match (
        .clk    (clk),
        .rst_n  (rst_n),
        .valid  (mreg_valid),
        .blocks (mreg_block),
        .key    (blk_q),
        .hit    (m_hit),
        .idx    (m_idx)
    );

    assign issuing = (ctl_q.st == ST_ISSUE);

    fpc_push_sel u_push (
        .clk     (clk),
        .rst_n   (rst_n),
        .active  (issuing),
        .need_i  (ctl_q.need_i),
        .need_d  (ctl_q.need_d),
        .need_wb (ctl_q.need_wb),
        .iq_full (iq_full),
        .dq_full (dq_full),
        .wb_full (wb_full),
        .iq_push (iq_push),
        .dq_push (dq_push),
        .wb_push (wb_push),
        .q_go    (q_go),
        .last    (last)
    );

    always_comb begin
        ctl_d        = ctl_q;
        blk_d        = blk_q;
        cmd_ready    = 1'b0;
        mreg_pend_we = 1'b0;
        tag_inval    = 1'b0;
        useless_pref = 1'b0;
        done         = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: begin
                cmd_ready = 1'b1;
                if (cmd_valid) begin
                    blk_d         = cmd_block;
                    ctl_d.flush   = cmd_flush;
                    ctl_d.need_i  = 1'b0;
                    ctl_d.need_d  = 1'b0;
                    ctl_d.need_wb = 1'b0;
                    ctl_d.l2hit   = 1'b0;
                    ctl_d.st      = ST_LOOKUP;
                end
            end
            ST_LOOKUP: begin
                if (m_hit) begin
                    mreg_pend_we = 1'b1;
                    ctl_d.st     = ST_DONE;
                end else if (tag_hit) begin
                    tag_inval     = 1'b1;
                    useless_pref  = tag_pref;
                    ctl_d.need_i  = 1'b1;
                    ctl_d.need_d  = ctl_q.flush && l1d_wb_mode;
                    ctl_d.need_wb = ctl_q.flush && tag_dirty;
                    ctl_d.l2hit   = 1'b1;
                    ctl_d.st      = ST_ISSUE;
                end else begin
                    ctl_d.st = ST_DONE;
                end
            end
            ST_ISSUE: begin
                if (q_go) begin
                    ctl_d.need_i = 1'b0;
                    ctl_d.need_d = 1'b0;
                end
                if (wb_push) ctl_d.need_wb = 1'b0;
                if (last)    ctl_d.st      = ST_DONE;
            end
            ST_DONE: begin
                done     = 1'b1;
                ctl_d.st = ST_IDLE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, default: 1'b0};
            blk_q <= '0;
        end else begin
            ctl_q <= ctl_d;
            blk_q <= blk_d;
        end
    end

    assign mreg_pend_idx   = m_idx;
    assign mreg_pend_flush = ctl_q.flush;
    assign tag_block       = blk_q;
    assign push_block      = blk_q;
    assign done_l2hit      = done && ctl_q.l2hit;

    // R10: an accepted command leaves the idle state at once
    a_r10_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    // R11: completion is followed by readiness
    a_r11_done_then_ready: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> cmd_ready && !done);

    // R2: a merge never touches the tag array
    a_r2_merge_no_tag: assert property (@(posedge clk) disable iff (!rst_n)
        mreg_pend_we |-> !tag_inval && !useless_pref);

    // R8: the line is invalidated once, never during the issue retries
    a_r8_tag_once: assert property (@(posedge clk) disable iff (!rst_n)
        tag_inval |=> !tag_inval && !cmd_ready);

    // R12: the useless-prefetch count only accompanies an invalidation
    a_r12_pref_with_inval: assert property (@(posedge clk) disable iff (!rst_n)
        useless_pref |-> tag_inval);

    // R9: the pushed block stays fixed while the command is in flight
    a_r9_block_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (iq_push || dq_push || wb_push) |-> $stable(push_block));

endmodule

// File: tb/flush_purge_ctrl_bench.sv
module flush_purge_ctrl_bench;

    localparam int NM = 8;
    localparam int BW = 20;
    localparam int IW = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cmd_valid = 1'b0, cmd_flush = 1'b0;
    logic [BW-1:0]    cmd_block = '0;
    logic [NM-1:0]    mreg_valid = '0;
    logic [NM*BW-1:0] mreg_block = '0;
    logic             tag_hit = 1'b0, tag_dirty = 1'b0, tag_pref = 1'b0;
    logic             l1d_wb_mode = 1'b0;
    logic             iq_full = 1'b0, dq_full = 1'b0, wb_full = 1'b0;
    logic             cmd_ready, mreg_pend_we, mreg_pend_flush, tag_inval;
    logic [IW-1:0]    mreg_pend_idx;
    logic [BW-1:0]    tag_block, push_block;
    logic             iq_push, dq_push, wb_push, done, done_l2hit, useless_pref;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    flush_purge_ctrl #(.NUM_MREG(NM), .BLK_W(BW)) u_flush_purge_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_flush(cmd_flush), .cmd_block(cmd_block), .mreg_valid(mreg_valid),
        .mreg_block(mreg_block), .mreg_pend_we(mreg_pend_we),
        .mreg_pend_idx(mreg_pend_idx), .mreg_pend_flush(mreg_pend_flush),
        .tag_block(tag_block), .tag_hit(tag_hit), .tag_dirty(tag_dirty),
        .tag_pref(tag_pref), .tag_inval(tag_inval), .l1d_wb_mode(l1d_wb_mode),
        .iq_push(iq_push), .iq_full(iq_full), .dq_push(dq_push), .dq_full(dq_full),
        .wb_push(wb_push), .wb_full(wb_full), .push_block(push_block),
        .done(done), .done_l2hit(done_l2hit), .useless_pref(useless_pref)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        for (int c = 0; c < 100000; c++) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual hung expected finished");
        summary();
    end

    // midx < 0: no valid match (slot 0 holds the block with valid clear)
    task automatic do_cmd(input bit fl, input logic [BW-1:0] blk, input int midx,
                          input bit hit, input bit dirty, input bit pref, input bit wbm,
                          input int iqf, input int dqf, input int wbf);
        bit m, qi, qd, wb, qpend, qok, ei, ed, ew;
        int cyc;
        m = (midx >= 0);
        for (int k = 0; k < NM; k++) begin
            mreg_valid[k] = 1'b1;
            mreg_block[k*BW +: BW] = blk + BW'(k + 1);
        end
        if (m) begin
            mreg_block[midx*BW +: BW] = blk;
            mreg_block[(NM-1)*BW +: BW] = blk;
        end else begin
            mreg_valid[0] = 1'b0;
            mreg_block[0 +: BW] = blk;
        end
        @(negedge clk);
        cmd_valid = 1'b1; cmd_flush = fl; cmd_block = blk;
        tag_hit = hit; tag_dirty = dirty; tag_pref = pref; l1d_wb_mode = wbm;
        #1;
        chk("R10 ready idle", cmd_ready, 1);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_block = ~blk;
        #1;
        // lookup cycle
        chk("R10 busy", cmd_ready, 0);
        chk("R2 pend_we", mreg_pend_we, m);
        if (m) begin
            chk("R2 pend_idx", mreg_pend_idx, midx);
            chk("R2 pend_flush", mreg_pend_flush, fl);
        end
        chk("R3 tag_inval", tag_inval, (!m && hit));
        chk("R12 useless_pref", useless_pref, (!m && hit && pref));
        chk("R2 tag_block", tag_block, blk);
        qi = !m && hit;
        qd = !m && hit && fl && wbm;
        wb = !m && hit && fl && dirty;
        cyc = 0;
        while ((qi || qd || wb) && cyc < 1000) begin
            @(negedge clk);
            iq_full = (cyc < iqf); dq_full = (cyc < dqf); wb_full = (cyc < wbf);
            #1;
            qpend = qi || qd;
            qok = !(qi && iq_full) && !(qd && dq_full);
            ei = qpend && qok && qi;
            ed = qpend && qok && qd;
            ew = !qpend && wb && !wb_full;
            chk("R5 R8 iq_push", iq_push, ei);
            chk("R6 R8 dq_push", dq_push, ed);
            chk("R7 R9 wb_push", wb_push, ew);
            chk("R8 no re-inval", tag_inval, 0);
            chk("R11 no early done", done, 0);
            if (iq_push || dq_push || wb_push) chk("R9 push_block", push_block, blk);
            if (qpend && qok) begin qi = 0; qd = 0; end
            else if (ew) wb = 0;
            cyc++;
        end
        @(negedge clk);
        iq_full = 1'b0; dq_full = 1'b0; wb_full = 1'b0;
        #1;
        chk("R11 done", done, 1);
        chk("R3 R4 done_l2hit", done_l2hit, (!m && hit));
        chk("R4 no push at done", int'(iq_push) + int'(dq_push) + int'(wb_push), 0);
        @(negedge clk);
        #1;
        chk("R11 ready after done", cmd_ready, 1);
        chk("R11 done one cycle", done, 0);
    endtask

    initial begin
        #22;
        #1;
        chk("R1 reset ready", cmd_ready, 1);
        chk("R1 reset done", done, 0);
        chk("R1 reset pushes", int'(iq_push) + int'(dq_push) + int'(wb_push), 0);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk("R1 idle outputs", int'(tag_inval) + int'(mreg_pend_we) + int'(useless_pref), 0);
        // R2: merges, lowest index wins
        do_cmd(1, 20'h01234, 2, 1, 1, 1, 1, 0, 0, 0);
        do_cmd(0, 20'h00777, 7, 1, 0, 0, 0, 0, 0, 0);
        // R4: invalid register ignored, tag miss
        do_cmd(1, 20'h0abcd, -1, 0, 1, 0, 1, 0, 0, 0);
        // R5 R6 R7: flush of dirty line, write-back mode
        do_cmd(1, 20'h00010, -1, 1, 1, 0, 1, 0, 0, 0);
        // R7 R12: dirty purge, prefetched line
        do_cmd(0, 20'h00020, -1, 1, 1, 1, 1, 0, 0, 0);
        // R6: flush, first-level data cache write-through, clean
        do_cmd(1, 20'h00030, -1, 1, 0, 0, 0, 0, 0, 0);
        // R8: instruction queue full for 3 cycles
        do_cmd(1, 20'h00040, -1, 1, 1, 0, 1, 3, 0, 0);
        // R8 R9: data queue full then pipe full longer
        do_cmd(1, 20'h00050, -1, 1, 1, 0, 1, 0, 2, 4);
        // R8: data queue full but not needed for a purge
        do_cmd(0, 20'h00060, -1, 1, 1, 0, 1, 0, 5, 5);
        // R9: pipe full only, data-side not required
        do_cmd(1, 20'h00070, -1, 1, 1, 0, 0, 0, 0, 3);
        summary();
    end

endmodule